// File: doc/BRIEF.md
# Line-Locked Subcarrier Phase Accumulator

This block is the phase generator for a colour subcarrier oscillator. A 32-bit accumulator adds a frequency word on every clock, and a later stage turns its top bits into sine samples. In normal operation the word is the programmed frequency register, used unchanged.

When the two-bit mode input selects line lock, the frequency word is rebuilt once per video line from a compensated increment that an upstream deserialiser has decoded from a lock stream. Each received word arrives with a strobe and a reset flag. It waits in a staging register until the next line-start pulse. At that pulse the increment becomes the upper 22 bits of the active word, and the lower 10 bits still come from the programmed register. A staged reset flag clears the accumulator at the same boundary.

Top module: `sc_lock_dds`

## Requirements
- R1: When mode_sel is not 2'b11, phase_out grows by exactly prog_word on every clock edge after reset.
- R2: Only mode code 2'b11 selects line lock. The codes 2'b00, 2'b01 and 2'b10 all use the full programmed word.
- R3: In line lock, after an increment is promoted, the active word is {increment[21:0], prog_word[9:0]}. The increment occupies bits 31:10 and the programmed bits 9:0 occupy bits 9:0.
- R4: A received increment has no effect on phase_out until the next line_start pulse. The edge that samples the pulse still adds the old word, and the new word is added from the following edge on.
- R5: If rx_valid and line_start are high in the same cycle, the pulse promotes the word staged earlier. The word that arrives in that cycle stays staged until the next pulse.
- R6: A staged word with rx_reset_flag set makes phase_out read 0 after the edge that samples the next line_start. Adding then resumes with the promoted word.
- R7: In line lock, the programmed word is used until the first promotion. Leaving line lock discards both the staged word and the active increment.
- R8: A synchronous reset makes phase_out 0 and makes the active word equal to prog_word.
- R9: The accumulator wraps modulo 2^32.
- R10: rx_valid is ignored while mode_sel is not 2'b11. After switching to line lock, a line_start pulse with nothing new received leaves the programmed word in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_word | input | 32 | Programmed frequency word |
| mode_sel | input | 2 | Frequency source select; 2'b11 selects line lock |
| rx_inc | input | 22 | Compensated increment decoded from the lock stream |
| rx_valid | input | 1 | One-cycle strobe marking rx_inc and rx_reset_flag as valid |
| rx_reset_flag | input | 1 | Received request to clear the accumulator at the next line start |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| phase_out | output | 32 | Accumulator phase |

## Verification
The assertions assume that rx_valid and line_start are single-cycle strobes sampled on the rising edge, and that prog_word and mode_sel are stable register values that change only between steps of the test, not in the middle of a line measurement. The stimulus drives every input on the falling edge, raises each strobe for exactly one cycle, and changes the mode or the programmed word only while no received word is waiting to be judged. Because of this, every per-edge phase step has a single expected value.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;
  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_LINE_LOCK = 2'b11;

  function automatic logic is_line_lock(input logic [MODE_W-1:0] m);
    return m == MODE_LINE_LOCK;
  endfunction
endpackage

// File: rtl/sc_dds_stage.sv
module sc_dds_stage #(
  parameter int unsigned INC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_en,
  input  logic             rx_valid,
  input  logic [INC_W-1:0] rx_inc,
  input  logic             rx_reset_flag,
  input  logic             line_start,
  output logic [INC_W-1:0] act_inc,
  output logic             act_valid,
  output logic             promote,
  output logic             clear_req
);
  logic [INC_W-1:0] stage_inc;
  logic             stage_rst;
  logic             pend;

  assign promote   = lock_en && line_start && pend;
  assign clear_req = promote && stage_rst;

  always_ff @(posedge clk) begin
    if (rst || !lock_en) begin
      stage_inc <= '0;
      stage_rst <= 1'b0;
      pend      <= 1'b0;
      act_valid <= 1'b0;
      act_inc   <= '0;
    end else begin
      if (promote) begin
        act_inc   <= stage_inc;
        act_valid <= 1'b1;
      end
      if (rx_valid) begin
        stage_inc <= rx_inc;
        stage_rst <= rx_reset_flag;
        pend      <= 1'b1;
      end else if (line_start) begin
        pend      <= 1'b0;
      end
    end
  end

  AST_ACT_HELD_MID_LINE: assert property (@(posedge clk) disable iff (rst)
    (lock_en && !line_start) |=> $stable(act_inc)); // R4
  AST_SAME_CYCLE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (lock_en && rx_valid && line_start) |=> pend); // R5
endmodule

// File: rtl/sc_dds_word_sel.sv
module sc_dds_word_sel #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned INC_W = 22
) (
  input  logic [ACC_W-1:0] prog_word,
  input  logic [INC_W-1:0] act_inc,
  input  logic             use_lock,
  output logic [ACC_W-1:0] step_word
);
  localparam int unsigned LOW_W = ACC_W - INC_W;

  function automatic logic [ACC_W-1:0] join_word(
    input logic [INC_W-1:0] inc, input logic [ACC_W-1:0] prog);
    return {inc, prog[LOW_W-1:0]};
  endfunction

  always_comb begin
    step_word = use_lock ? join_word(act_inc, prog_word) : prog_word;
  end
endmodule

// File: rtl/sc_dds_accum.sv
module sc_dds_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  function automatic logic [ACC_W-1:0] next_phase(
    input logic [ACC_W-1:0] cur, input logic [ACC_W-1:0] inc);
    return cur + inc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else              phase <= next_phase(phase, step);
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (phase == '0)); // R6
  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !$past(rst)) |=> (phase == ACC_W'($past(phase) + $past(step)))); // R9
endmodule

// File: rtl/sc_lock_dds.sv
module sc_lock_dds #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned INC_W = 22
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ACC_W-1:0]                   prog_word,
  input  logic [sc_dds_pkg::MODE_W-1:0]      mode_sel,
  input  logic [INC_W-1:0]                   rx_inc,
  input  logic                               rx_valid,
  input  logic                               rx_reset_flag,
  input  logic                               line_start,
  output logic [ACC_W-1:0]                   phase_out
);
  import sc_dds_pkg::*;
  localparam int unsigned LOW_W = ACC_W - INC_W;

  logic             lock_en;
  logic [INC_W-1:0] act_inc;
  logic             act_valid;
  logic             promote;
  logic             clear_req;
  logic             use_lock;
  logic [ACC_W-1:0] step_word;

  assign lock_en  = is_line_lock(mode_sel);
  assign use_lock = lock_en && act_valid;

  sc_dds_stage #(.INC_W(INC_W)) u_stage (
    .clk(clk), .rst(rst), .lock_en(lock_en), .rx_valid(rx_valid),
    .rx_inc(rx_inc), .rx_reset_flag(rx_reset_flag), .line_start(line_start),
    .act_inc(act_inc), .act_valid(act_valid), .promote(promote),
    .clear_req(clear_req)
  );

  sc_dds_word_sel #(.ACC_W(ACC_W), .INC_W(INC_W)) u_sel (
    .prog_word(prog_word), .act_inc(act_inc), .use_lock(use_lock),
    .step_word(step_word)
  );

  sc_dds_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clear(clear_req), .step(step_word),
    .phase(phase_out)
  );

  AST_FREE_USES_PROG: assert property (@(posedge clk) disable iff (rst)
    !lock_en |-> (step_word == prog_word)); // R2
  AST_LOCK_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    lock_en |-> (step_word[LOW_W-1:0] == prog_word[LOW_W-1:0])); // R3
  AST_NO_LOCK_BEFORE_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (!lock_en) |=> !act_valid); // R7
  AST_CLEAR_ONLY_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    clear_req |-> (line_start && lock_en)); // R6
endmodule

// File: tb/sc_lock_dds_test.sv
`timescale 1ns/1ps
module sc_lock_dds_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] prog_word = 32'h0;
  logic [1:0]  mode_sel = 2'b00;
  logic [21:0] rx_inc = '0;
  logic        rx_valid = 1'b0;
  logic        rx_reset_flag = 1'b0;
  logic        line_start = 1'b0;
  logic [31:0] phase_out;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R8";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_lock_dds uut (
    .clk(clk), .rst(rst), .prog_word(prog_word), .mode_sel(mode_sel),
    .rx_inc(rx_inc), .rx_valid(rx_valid), .rx_reset_flag(rx_reset_flag),
    .line_start(line_start), .phase_out(phase_out)
  );

  // Behavioural reference model
  longint unsigned m_acc = 0;
  int unsigned m_stage = 0, m_active = 0;
  bit m_stage_rst = 0, m_pend = 0, m_have = 0, m_started = 0;

  always @(posedge clk) begin
    longint unsigned w;
    bit lockm;
    if (rst) begin
      m_acc = 0; m_pend = 0; m_have = 0; m_stage = 0; m_stage_rst = 0;
      m_started = 1;
    end else begin
      lockm = (mode_sel == 2'd3);
      if (lockm && m_have) w = longint'(m_active) * 1024 + (prog_word % 1024);
      else w = prog_word;
      if (lockm && line_start && m_pend && m_stage_rst) m_acc = 0;
      else m_acc = (m_acc + w) % 64'h1_0000_0000;
      if (!lockm) begin
        m_pend = 0; m_have = 0;
      end else begin
        if (line_start && m_pend) begin
          m_active = m_stage; m_have = 1;
        end
        if (rx_valid) begin
          m_stage = rx_inc; m_stage_rst = rx_reset_flag; m_pend = 1;
        end else if (line_start) m_pend = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_started && !done) check(cur_req, phase_out, m_acc[31:0]);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic get_delta(output logic [31:0] d);
    logic [31:0] p0;
    p0 = phase_out; tick(); d = phase_out - p0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1; tick(); line_start = 1'b0;
  endtask

  task automatic send(input logic [21:0] v, input logic rf);
    rx_inc = v; rx_reset_flag = rf; rx_valid = 1'b1; tick();
    rx_valid = 1'b0; rx_reset_flag = 1'b0;
  endtask

  initial begin
    #(200000 * 5.0);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pw;
    pw = 32'h0123_4567;
    tick(); tick();
    prog_word = pw;
    check("R8", phase_out, 32'h0);
    rst = 1'b0;
    tick();
    check("R8", phase_out, pw);

    cur_req = "R1";
    get_delta(d); check("R1", d, pw);
    for (int m = 0; m < 3; m++) begin
      cur_req = "R2";
      mode_sel = 2'(m); tick();
      get_delta(d); check("R2", d, pw);
    end

    cur_req = "R10";
    mode_sel = 2'b00;
    send(22'h155555, 1'b0);
    mode_sel = 2'b11; tick();
    pulse_line();
    get_delta(d); check("R10", d, pw);
    get_delta(d); check("R7", d, pw);

    cur_req = "R4";
    send(22'h2AAAAA, 1'b0);
    get_delta(d); check("R4", d, pw);
    pulse_line();
    cur_req = "R3";
    get_delta(d); check("R3", d, {22'h2AAAAA, pw[9:0]});

    cur_req = "R5";
    send(22'h000123, 1'b0);
    rx_inc = 22'h3FFF00; rx_valid = 1'b1; line_start = 1'b1; tick();
    rx_valid = 1'b0; line_start = 1'b0;
    get_delta(d); check("R5", d, {22'h000123, pw[9:0]});
    pulse_line();
    get_delta(d); check("R5", d, {22'h3FFF00, pw[9:0]});

    cur_req = "R6";
    send(22'h001000, 1'b1);
    tick();
    pulse_line();
    check("R6", phase_out, 32'h0);
    get_delta(d); check("R6", d, {22'h001000, pw[9:0]});

    cur_req = "R7";
    mode_sel = 2'b00; tick();
    get_delta(d); check("R7", d, pw);
    mode_sel = 2'b11; tick();
    get_delta(d); check("R7", d, pw);

    cur_req = "R9";
    mode_sel = 2'b01;
    prog_word = 32'hC000_0001; tick();
    for (int i = 0; i < 3; i++) begin
      get_delta(d); check("R9", d, 32'hC000_0001);
    end

    cur_req = "R8";
    rst = 1'b1; tick();
    check("R8", phase_out, 32'h0);
    rst = 1'b0; mode_sel = 2'b11; tick();
    get_delta(d); check("R8", d, 32'hC000_0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule